// File: doc/BRIEF.md
# Dual Input Clock Supervisor with Switchover

This block watches two reference clocks that feed a downstream clock generator and chooses which of them is passed through to the generator. Input 0 is the primary and input 1 is the secondary. A free-running monitor clock samples a toggle bit from each input, and an input whose toggle bit stops changing for a set number of monitor cycles is flagged as bad. The selected clock leaves through a glitch-free multiplexer that hands over between the two inputs without creating a runt pulse.

A parameter fixes the mode at elaboration. In automatic mode a switchover is started by a loss-of-lock report from the generator, by the active input stopping, or by a rising edge on the switch request. In manual mode only the switch request counts. Once a switchover has started, a programmable number of monitor cycles passes before the selection changes. The block never switches onto an input that is flagged bad. After each change a guard period of the same length must pass before another switchover can start.

Top module: `clksw_top`

## Requirements
- R1: After reset `sel_active` is 0 (input 0 active), `sw_busy` is 0, and both `bad0` and `bad1` are 0.
- R2: `sel_active` is 0 while `clk_out` follows `clk_in0` and 1 while it follows `clk_in1`. Once the handover has settled, `clk_out` equals the selected input.
- R3: `bad0` rises when `clk_in0` has made no edge for STALL_CYCLES monitor cycles and falls again once it toggles. `bad1` does the same for `clk_in1`. An input that keeps toggling keeps its flag low.
- R4: In automatic mode a high level on `lock_lost` starts a switchover to the other input.
- R5: In automatic mode, the flag of the active input going high starts a switchover to the other input.
- R6: In automatic mode a rising edge on `sw_req` starts a switchover to the other input.
- R7: `sw_busy` stays high for exactly WAIT_CYCLES monitor cycles. `sel_active` toggles on the same edge at which `sw_busy` falls, and at no other time.
- R8: `sw_busy` is high only while a switchover is pending and is low when the block is idle.
- R9: For WAIT_CYCLES monitor cycles after `sel_active` changes, every trigger is ignored: no switchover starts and the request is not kept for later.
- R10: A trigger whose target input is flagged bad is ignored: `sel_active` is unchanged and `sw_busy` stays low. If the target goes bad during the wait, the pending switchover is dropped.
- R11: One rising edge on `sw_req` gives at most one toggle of `sel_active`, however long the request is held high.
- R12: With AUTO_MODE = 0, neither `lock_lost` nor a stopped input changes the selection. Only a rising edge on `sw_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| clk_in0 | input | 1 | Primary reference clock |
| clk_in1 | input | 1 | Secondary reference clock |
| lock_lost | input | 1 | Loss-of-lock report from the downstream generator, level |
| sw_req | input | 1 | Switch request, acted on at its rising edge |
| clk_out | output | 1 | Selected clock, glitch-free |
| sel_active | output | 1 | Active input: 0 = clk_in0, 1 = clk_in1 |
| bad0 | output | 1 | clk_in0 has stopped toggling |
| bad1 | output | 1 | clk_in1 has stopped toggling |
| sw_busy | output | 1 | A switchover has started and is waiting |

## Verification
The hardest case to reach from the ports is a switchover triggered by the active clock itself dying. In that case the multiplexer has to release an enable whose own clock no longer runs, and the bench has to show that the output picks up the other input. The bench reaches this case by stopping the generator of `clk_in0` while it is selected. It then lets the stall counter expire and samples `clk_out` against `clk_in1` at odd times that never coincide with an input edge. Random mixes of request pulses and loss-of-lock pulses, with random widths and gaps, drive the selection against a toggle model. Directed steps place a request inside the guard window and aim a request at a stopped input.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
   typedef enum logic [1:0] {
      SW_IDLE  = 2'd0,
      SW_WAIT  = 2'd1,
      SW_GUARD = 2'd2
   } sw_state_e;
endpackage

// File: rtl/clksw_sync.sv
// Multi-stage resynchroniser into the clock of the caller.
module clksw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clksw_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_activity.sv
// Activity detector: a toggle bit in the watched clock domain is brought
// into the monitor domain. If it stays unchanged too long, the input is bad.
module clksw_activity #(
   parameter int unsigned STALL_CYCLES = 16,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk_src,
   input  logic clk_mon,
   input  logic rst_n,
   output logic bad
);
   localparam int unsigned CW = $clog2(STALL_CYCLES);

   logic          tgl;
   logic          tgl_s;
   logic          tgl_d;
   logic [CW-1:0] idle_cnt;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) tgl <= 1'b0;
      else        tgl <= ~tgl;
   end

   clksw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_mon),
      .rst_n (rst_n),
      .d     (tgl),
      .q     (tgl_s)
   );

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
         tgl_d    <= 1'b0;
         idle_cnt <= '0;
         bad      <= 1'b0;
      end else begin
         tgl_d <= tgl_s;
         if (tgl_s != tgl_d) begin
            idle_cnt <= '0;
            bad      <= 1'b0;
         end else if (idle_cnt == CW'(STALL_CYCLES - 1)) begin
            bad      <= 1'b1;
         end else begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clksw_ctrl.sv
// Switchover sequencer in the monitor clock domain.
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter bit          AUTO_MODE   = 1'b1,
   parameter int unsigned WAIT_CYCLES = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_mon,
   input  logic       rst_n,
   input  logic       lock_lost,
   input  logic       sw_req,
   input  logic [1:0] bad,
   output logic       sel,
   output logic       busy
);
   localparam int unsigned WW = $clog2(WAIT_CYCLES);

   sw_state_e     state;
   logic [WW-1:0] cnt;
   logic          lock_s;
   logic          req_s;
   logic          req_d;
   logic          req_rise;
   logic          trig;
   logic          tgt;
   logic          tgt_bad;

   clksw_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
      .clk (clk_mon), .rst_n (rst_n), .d (lock_lost), .q (lock_s)
   );
   clksw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk (clk_mon), .rst_n (rst_n), .d (sw_req), .q (req_s)
   );

   assign req_rise = req_s & ~req_d;
   assign tgt      = ~sel;
   assign tgt_bad  = bad[tgt];

   generate
      if (AUTO_MODE) begin : g_auto
         assign trig = req_rise | lock_s | bad[sel];
      end else begin : g_manual
         logic unused_auto;
         assign unused_auto = lock_s;
         assign trig        = req_rise;
      end
   endgenerate

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
         state <= SW_IDLE;
         cnt   <= '0;
         sel   <= 1'b0;
         req_d <= 1'b0;
      end else begin
         req_d <= req_s;
         unique case (state)
            SW_IDLE: begin
               if (trig && !tgt_bad) begin
                  state <= SW_WAIT;
                  cnt   <= WW'(WAIT_CYCLES - 1);
               end
            end
            SW_WAIT: begin
               if (tgt_bad) begin
                  state <= SW_IDLE;
               end else if (cnt == '0) begin
                  sel   <= tgt;
                  state <= SW_GUARD;
                  cnt   <= WW'(WAIT_CYCLES - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SW_GUARD: begin
               if (cnt == '0) state <= SW_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= SW_IDLE;
         endcase
      end
   end

   assign busy = (state == SW_WAIT);
endmodule

// File: rtl/clksw_gmux.sv
// Glitch-free two-input clock multiplexer. Each lane releases its enable
// only after the other lane's enable has dropped. The enable is taken on
// the rising edge and applied on the falling edge of the lane's own clock.
// A lane whose input is flagged bad is cleared asynchronously, because its
// own clock can no longer clear it.
module clksw_gmux #(
   parameter int unsigned LANES = 2
) (
   input  logic [LANES-1:0] clk_src,
   input  logic             rst_n,
   input  logic             sel,
   input  logic [LANES-1:0] bad,
   output logic             clk_out
);
   logic [LANES-1:0] en;

   generate
      if (LANES != 2) begin : g_bad_lanes
         $error("clksw_gmux: exactly two lanes supported");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic lane_rst_n;
         logic want_q;
         logic en_q;

         assign lane_rst_n = rst_n & ~bad[i];

         always_ff @(posedge clk_src[i] or negedge lane_rst_n) begin
            if (!lane_rst_n) want_q <= 1'b0;
            else             want_q <= (sel == 1'(i)) & ~en[LANES-1-i];
         end

         always_ff @(negedge clk_src[i] or negedge lane_rst_n) begin
            if (!lane_rst_n) en_q <= 1'b0;
            else             en_q <= want_q;
         end

         assign en[i] = en_q;
      end
   endgenerate

   assign clk_out = |(clk_src & en);
endmodule

// File: rtl/clksw_top.sv
module clksw_top #(
   parameter bit          AUTO_MODE    = 1'b1,
   parameter int unsigned STALL_CYCLES = 16,
   parameter int unsigned WAIT_CYCLES  = 8,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk_mon,
   input  logic rst_n,
   input  logic clk_in0,
   input  logic clk_in1,
   input  logic lock_lost,
   input  logic sw_req,
   output logic clk_out,
   output logic sel_active,
   output logic bad0,
   output logic bad1,
   output logic sw_busy
);
   localparam int unsigned NUM_IN = 2;

   logic [NUM_IN-1:0] clk_src;
   logic [NUM_IN-1:0] bad;

   generate
      if (STALL_CYCLES < 4) begin : g_chk_stall
         $error("clksw_top: STALL_CYCLES must be at least 4");
      end
      if (WAIT_CYCLES < 2) begin : g_chk_wait
         $error("clksw_top: WAIT_CYCLES must be at least 2");
      end
   endgenerate

   assign clk_src = {clk_in1, clk_in0};

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_mon
         clksw_activity #(
            .STALL_CYCLES (STALL_CYCLES),
            .SYNC_STAGES  (SYNC_STAGES)
         ) u_act (
            .clk_src (clk_src[i]),
            .clk_mon (clk_mon),
            .rst_n   (rst_n),
            .bad     (bad[i])
         );
      end
   endgenerate

   clksw_ctrl #(
      .AUTO_MODE   (AUTO_MODE),
      .WAIT_CYCLES (WAIT_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ctrl (
      .clk_mon   (clk_mon),
      .rst_n     (rst_n),
      .lock_lost (lock_lost),
      .sw_req    (sw_req),
      .bad       (bad),
      .sel       (sel_active),
      .busy      (sw_busy)
   );

   clksw_gmux #(.LANES(NUM_IN)) u_gmux (
      .clk_src (clk_src),
      .rst_n   (rst_n),
      .sel     (sel_active),
      .bad     (bad),
      .clk_out (clk_out)
   );

   assign bad0 = bad[0];
   assign bad1 = bad[1];
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
   parameter int unsigned WAIT_CYCLES = 8
) (
   input logic clk_mon,
   input logic rst_n,
   input logic sel_active,
   input logic sw_busy,
   input logic bad0,
   input logic bad1
);
   localparam int unsigned QW = $clog2(WAIT_CYCLES + 2);

   logic [QW-1:0] busy_run;
   logic [QW-1:0] quiet;
   logic          sel_q;

   always_ff @(posedge clk_mon or negedge rst_n) begin
      if (!rst_n) begin
         busy_run <= '0;
         quiet    <= QW'(WAIT_CYCLES);
         sel_q    <= 1'b0;
      end else begin
         sel_q <= sel_active;
         if (!sw_busy)                            busy_run <= '0;
         else if (busy_run != QW'(WAIT_CYCLES+1)) busy_run <= busy_run + 1'b1;
         if (sel_active != sel_q)                 quiet <= '0;
         else if (quiet != QW'(WAIT_CYCLES))      quiet <= quiet + 1'b1;
      end
   end

   // R7: the selection only moves on the edge where busy ends
   p_sel_on_busy_end_r7: assert property (@(posedge clk_mon) disable iff (!rst_n)
      (sel_active != $past(sel_active)) |-> ($past(sw_busy) && !sw_busy));

   // R7: busy never outlasts the wait period
   p_busy_len_r7: assert property (@(posedge clk_mon) disable iff (!rst_n)
      sw_busy |-> (busy_run < QW'(WAIT_CYCLES)));

   // R10: never land on an input that was flagged bad
   p_no_bad_target_r10: assert property (@(posedge clk_mon) disable iff (!rst_n)
      (sel_active != $past(sel_active)) |->
         ($past(sel_active) ? !$past(bad0) : !$past(bad1)));

   // R9: a new switchover waits out the guard period
   p_guard_r9: assert property (@(posedge clk_mon) disable iff (!rst_n)
      $rose(sw_busy) |-> (quiet >= QW'(WAIT_CYCLES - 1)));
endmodule

bind clksw_top clksw_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_clksw_chk (
   .clk_mon    (clk_mon),
   .rst_n      (rst_n),
   .sel_active (sel_active),
   .sw_busy    (sw_busy),
   .bad0       (bad0),
   .bad1       (bad1)
);

// File: tb/test_clksw_top.sv
module test_clksw_top;
   localparam int WAITC = 8;

   logic clk_mon = 1'b0;
   logic rst_n   = 1'b0;
   logic clk0    = 1'b0;
   logic clk1    = 1'b0;
   logic run0    = 1'b1;
   logic run1    = 1'b1;
   logic a_lock  = 1'b0, a_req = 1'b0;
   logic m_lock  = 1'b0, m_req = 1'b0;
   logic a_out, a_sel, a_bad0, a_bad1, a_busy;
   logic m_out, m_sel, m_bad0, m_bad1, m_busy;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4  clk_mon = ~clk_mon;
   always #10 clk0 = run0 ? ~clk0 : clk0;
   always #14 clk1 = run1 ? ~clk1 : clk1;

   clksw_top #(.AUTO_MODE(1'b1), .WAIT_CYCLES(WAITC)) i_clksw_top (
      .clk_mon(clk_mon), .rst_n(rst_n), .clk_in0(clk0), .clk_in1(clk1),
      .lock_lost(a_lock), .sw_req(a_req), .clk_out(a_out),
      .sel_active(a_sel), .bad0(a_bad0), .bad1(a_bad1), .sw_busy(a_busy));

   clksw_top #(.AUTO_MODE(1'b0), .WAIT_CYCLES(WAITC)) i_clksw_top_man (
      .clk_mon(clk_mon), .rst_n(rst_n), .clk_in0(clk0), .clk_in1(clk1),
      .lock_lost(m_lock), .sw_req(m_req), .clk_out(m_out),
      .sel_active(m_sel), .bad0(m_bad0), .bad1(m_bad1), .sw_busy(m_busy));

   function automatic logic toggled(logic s);
      return ~s;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk_mon);
   endtask

   // Count cycles with busy high over a window, to show it never rose.
   task automatic watch_busy(input int n, output int seen);
      seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk_mon);
         if (a_busy) seen++;
      end
   endtask

   // Sample clk_out at odd times, which never coincide with an input edge.
   task automatic follow(string req, logic exp_sel);
      int bad_cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk_mon);
         #1;
         if (a_out !== (exp_sel ? clk1 : clk0)) bad_cnt++;
      end
      check(req, bad_cnt, 0);
   endtask

   task automatic pulse(ref logic sig, input int len);
      @(negedge clk_mon);
      sig = 1'b1;
      cyc(len);
      sig = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seen;
      int blen;
      logic exp_sel;
      void'($urandom(32'd20251));

      // R1: reset state
      cyc(3);
      check("R1 sel", a_sel, 0);
      check("R1 busy", a_busy, 0);
      check("R1 bad", {a_bad1, a_bad0}, 0);
      cyc(2);
      rst_n = 1'b1;
      cyc(40);
      // R3: running inputs keep the flags low
      check("R3 both running", {a_bad1, a_bad0}, 0);
      // R2: output follows input 0
      follow("R2 clk_out=clk_in0", 1'b0);

      // R6/R7: request starts a switchover of exactly WAITC busy cycles
      pulse(a_req, 2);
      seen = 0;
      for (int k = 0; k < 20 && !a_busy; k++) @(negedge clk_mon);
      check("R8 busy rises", a_busy, 1);
      blen = 0;
      while (a_busy && blen < 40) begin
         check("R7 sel held while busy", a_sel, 0);
         blen++;
         @(negedge clk_mon);
      end
      check("R7 busy length", blen, WAITC);
      check("R6 switched to 1", a_sel, 1);
      // R9: request inside the guard window is dropped
      pulse(a_req, 2);
      watch_busy(30, seen);
      check("R9 no busy in guard", seen, 0);
      check("R9 sel unchanged", a_sel, 1);
      // R11: a long request yields one toggle
      pulse(a_req, 12);
      cyc(40);
      check("R11 single toggle", a_sel, 0);
      follow("R2 back on clk_in0", 1'b0);

      // Random mix of requests and loss-of-lock pulses (R4, R6)
      exp_sel = 1'b0;
      for (int it = 0; it < 16; it++) begin
         int len = 1 + int'($urandom_range(4));
         if ($urandom_range(1) == 0) pulse(a_req, len);
         else                        pulse(a_lock, len);
         exp_sel = toggled(exp_sel);
         cyc(25 + int'($urandom_range(15)));
         check("R4/R6 random toggle", a_sel, exp_sel);
      end
      follow("R2 random end", exp_sel);
      if (exp_sel) begin
         pulse(a_req, 2);
         cyc(30);
      end
      check("R6 realign to 0", a_sel, 0);

      // R10: target input stopped
      run1 = 1'b0;
      cyc(40);
      check("R3 bad1 after stop", a_bad1, 1);
      check("R3 bad0 still low", a_bad0, 0);
      pulse(a_req, 2);
      watch_busy(30, seen);
      check("R10 no busy to bad target", seen, 0);
      check("R10 sel kept", a_sel, 0);
      pulse(a_lock, 2);
      watch_busy(30, seen);
      check("R10 lock ignored to bad target", seen + int'(a_sel), 0);
      run1 = 1'b1;
      cyc(40);
      check("R3 bad1 clears", a_bad1, 0);

      // R5: active input dies, switch to input 1
      run0 = 1'b0;
      cyc(60);
      check("R3 bad0 after stop", a_bad0, 1);
      check("R5 switched away from dead input", a_sel, 1);
      follow("R2 clk_out=clk_in1 after failover", 1'b1);
      run0 = 1'b1;
      cyc(40);
      check("R3 bad0 clears", a_bad0, 0);
      check("R5 stays on 1", a_sel, 1);

      // R4: loss of lock returns to input 0; R8 idle afterwards
      pulse(a_lock, 2);
      cyc(30);
      check("R4 lock switch", a_sel, 0);
      check("R8 idle busy low", a_busy, 0);

      // R12: manual mode ignores a dead clock and lock loss
      check("R12 manual initial", m_sel, 0);
      run0 = 1'b0;
      cyc(60);
      check("R12 manual bad0 seen", m_bad0, 1);
      check("R12 dead clock ignored", m_sel, 0);
      pulse(m_lock, 3);
      cyc(30);
      check("R12 lock ignored", {m_busy, m_sel}, 0);
      run0 = 1'b1;
      cyc(40);
      pulse(m_req, 2);
      cyc(30);
      check("R12 request switches", m_sel, 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule